// File: doc/BRIEF.md
# Multi-Size Address Translation Buffer

This block translates a virtual address into a physical address for a single access stream. It holds a set of translation entries and compares all of them against every request in the same cycle. Each entry covers one page. The page size is set per entry and may be 4 KB, 16 KB, 512 KB or 8 MB. Each entry also carries an address-space tag, a protection-group number, cache attributes and, for 4 KB pages, protection at 1 KB granularity.

Software maintains the contents, because no hardware walks the page tables. A write either names the target slot or takes the slot offered by a round-robin pointer. A single strobe drops every entry at once. A lookup that finds no entry only raises a miss flag, and the miss handler is expected to fill the buffer and retry.

Top module: `tlb_xlate`

## Requirements
- R1: The buffer holds ENTRIES (default 32) entries. Each lookup compares every valid entry, and the result is registered: `rsp_valid` rises on the clock edge after the one that samples `req_valid`, and stays low when no request was sampled.
- R2: The page size code is 0 for 4 KB, 1 for 16 KB, 2 for 512 KB and 3 for 8 MB. The tag compare ignores the virtual page bits below the entry's page size, which are none, VA[13:12], VA[18:12] and VA[22:12] in that order. An address one page above the mapped page misses.
- R3: On a hit, `rsp_pa` takes the entry's frame bits above the page size and the request's address bits below it. Bits [11:0] always come from the request.
- R4: A hit requires `req_asid` to equal the entry's address-space tag. The same page tag under a different identifier misses.
- R5: On a hit, the matched entry's protection group, cache-inhibit bit and write-through bit (1 = write-through, 0 = copyback) appear on `rsp_group`, `rsp_ci` and `rsp_wt`.
- R6: For a 4 KB page, `rsp_subprot` is bit VA[11:10] of the entry's 4-bit protection field. For larger pages it is bit 0 of that field.
- R7: When no entry matches, `rsp_miss` is 1, `rsp_hit` is 0, and `rsp_pa`, `rsp_group`, `rsp_ci`, `rsp_wt` and `rsp_subprot` are all zero. After reset no entry is valid.
- R8: When several entries match, the lowest-numbered one supplies the result and `rsp_multi` is 1, along with `rsp_hit`.
- R9: A write with `wr_use_idx`=1 loads slot `wr_idx`, marks it valid, and leaves `victim_idx` unchanged.
- R10: A write with `wr_use_idx`=0 loads slot `victim_idx`. The pointer then advances by one and wraps from ENTRIES-1 to 0. It resets to 0.
- R11: `inval_all` clears every valid bit in one cycle. A write in the same cycle is dropped and does not move the pointer.
- R12: A lookup sampled on the same edge as a write sees the contents that were present before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Address-space identifier of the request |
| wr_en | input | 1 | Entry write strobe |
| wr_use_idx | input | 1 | 1 = write slot `wr_idx`, 0 = write slot `victim_idx` |
| wr_idx | input | IDX_W | Explicit slot number |
| wr_vpn | input | VA_W-12 | Virtual page tag (VA[VA_W-1:12]) |
| wr_asid | input | ASID_W | Address-space tag |
| wr_size | input | 2 | Page size code (see R2) |
| wr_pfn | input | PA_W-12 | Physical frame bits (PA[PA_W-1:12]) |
| wr_group | input | GRP_W | Protection group number |
| wr_ci | input | 1 | Cache-inhibit attribute |
| wr_wt | input | 1 | Write-through attribute |
| wr_prot | input | 4 | Protection bits, one for each 1 KB quarter of a 4 KB page |
| inval_all | input | 1 | Invalidate every entry |
| victim_idx | output | IDX_W | Round-robin replacement slot |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation found |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_pa | output | PA_W | Physical address |
| rsp_group | output | GRP_W | Protection group of the matched entry |
| rsp_ci | output | 1 | Cache-inhibit of the matched entry |
| rsp_wt | output | 1 | Write-through of the matched entry |
| rsp_subprot | output | 1 | Selected protection bit (see R6) |

## Verification
Every lookup result is due on the first clock edge after the edge that samples the request. The bench drives each request at a falling edge, waits for the next rising edge and samples 1 ns later. Writes, invalidations and pointer moves take effect on the edge that samples them. The pointer is read back right after that edge, and a lookup in the following cycle shows the new contents. The same-cycle case is checked by presenting a write and a lookup together and expecting the old mapping first and the new one on the next request.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

   localparam int PG_LSB = 12;   // smallest page: 4 KB
   localparam int IGN_W  = 11;   // widest ignore field: 8 MB vs 4 KB

   typedef enum logic [1:0] {
      PG_4K   = 2'd0,
      PG_16K  = 2'd1,
      PG_512K = 2'd2,
      PG_8M   = 2'd3
   } pg_size_e;

   // page-number bits (relative to bit 12) that lie inside the page
   function automatic logic [IGN_W-1:0] pg_ign_mask(input logic [1:0] sz);
      case (pg_size_e'(sz))
         PG_4K:   return 11'h000;
         PG_16K:  return 11'h003;
         PG_512K: return 11'h07F;
         default: return 11'h7FF;
      endcase
   endfunction

endpackage

// File: rtl/tlb_xlate_match.sv
module tlb_xlate_match
   import tlb_xlate_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 4
) (
   input  logic              e_valid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [ASID_W-1:0] e_asid,
   input  logic [1:0]        e_size,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   output logic              hit
);
   logic [VPN_W-1:0] care;

   always_comb begin
      care = ~VPN_W'(pg_ign_mask(e_size));
      hit  = e_valid && (e_asid == q_asid) && (((e_vpn ^ q_vpn) & care) == '0);
   end
endmodule

// File: rtl/tlb_xlate_pick.sv
module tlb_xlate_pick #(
   parameter int N = 32,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     hits,
   output logic [IDX_W-1:0] sel,
   output logic             any,
   output logic             multi
);
   always_comb begin
      sel = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) begin
            sel = IDX_W'(i);
            any = 1'b1;
         end
      end
      multi = (hits & (hits - 1'b1)) != '0;
   end
endmodule

// File: rtl/tlb_xlate_rr.sv
module tlb_xlate_rr #(
   parameter int N = 32,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv)
         ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_xlate_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int ASID_W  = 4,
   parameter int GRP_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int VPN_W  = VA_W - PG_LSB,
   localparam int PFN_W  = PA_W - PG_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              wr_en,
   input  logic              wr_use_idx,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [1:0]        wr_size,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic [GRP_W-1:0]  wr_group,
   input  logic              wr_ci,
   input  logic              wr_wt,
   input  logic [3:0]        wr_prot,
   input  logic              inval_all,
   output logic [IDX_W-1:0]  victim_idx,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_multi,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [GRP_W-1:0]  rsp_group,
   output logic              rsp_ci,
   output logic              rsp_wt,
   output logic              rsp_subprot
);
   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_xlate: ENTRIES must be at least 2");
   end
   if (VPN_W < IGN_W + 1) begin : g_bad_va
      $error("tlb_xlate: VA_W must cover an 8 MB page plus one tag bit");
   end
   if (PFN_W < IGN_W + 1) begin : g_bad_pa
      $error("tlb_xlate: PA_W must cover an 8 MB frame plus one bit");
   end

   localparam logic [IDX_W:0] N_LIM = (IDX_W + 1)'(ENTRIES);

   // entry storage
   logic [ENTRIES-1:0] e_valid;
   logic [VPN_W-1:0]   e_vpn   [ENTRIES];
   logic [ASID_W-1:0]  e_asid  [ENTRIES];
   logic [1:0]         e_size  [ENTRIES];
   logic [PFN_W-1:0]   e_pfn   [ENTRIES];
   logic [GRP_W-1:0]   e_group [ENTRIES];
   logic               e_ci    [ENTRIES];
   logic               e_wt    [ENTRIES];
   logic [3:0]         e_prot  [ENTRIES];

   logic [IDX_W-1:0] wr_slot;
   logic             wr_go;
   logic             rr_adv;

   assign wr_slot = wr_use_idx ? wr_idx : victim_idx;
   assign wr_go   = wr_en && !inval_all && ({1'b0, wr_slot} < N_LIM);
   assign rr_adv  = wr_en && !wr_use_idx && !inval_all;

   tlb_xlate_rr #(.N(ENTRIES)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rr_adv),
      .ptr   (victim_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         e_valid <= '0;
      else if (inval_all)
         e_valid <= '0;
      else if (wr_go)
         e_valid[wr_slot] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_go) begin
         e_vpn[wr_slot]   <= wr_vpn;
         e_asid[wr_slot]  <= wr_asid;
         e_size[wr_slot]  <= wr_size;
         e_pfn[wr_slot]   <= wr_pfn;
         e_group[wr_slot] <= wr_group;
         e_ci[wr_slot]    <= wr_ci;
         e_wt[wr_slot]    <= wr_wt;
         e_prot[wr_slot]  <= wr_prot;
      end
   end

   // parallel compare
   logic [ENTRIES-1:0] hits;
   logic [VPN_W-1:0]   q_vpn;

   assign q_vpn = req_va[VA_W-1:PG_LSB];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      tlb_xlate_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
         .e_valid (e_valid[g]),
         .e_vpn   (e_vpn[g]),
         .e_asid  (e_asid[g]),
         .e_size  (e_size[g]),
         .q_vpn   (q_vpn),
         .q_asid  (req_asid),
         .hit     (hits[g])
      );
   end

   logic [IDX_W-1:0] sel;
   logic             any_hit;
   logic             multi_hit;

   tlb_xlate_pick #(.N(ENTRIES)) u_pick (
      .hits  (hits),
      .sel   (sel),
      .any   (any_hit),
      .multi (multi_hit)
   );

   // address composition from the winning entry
   logic [PFN_W-1:0] keep_req;
   logic [PFN_W-1:0] pa_hi;
   logic [PA_W-1:0]  pa_c;
   logic             sp_c;

   always_comb begin
      keep_req = PFN_W'(pg_ign_mask(e_size[sel]));
      pa_hi    = (e_pfn[sel] & ~keep_req)
               | (PFN_W'(req_va[PG_LSB+IGN_W-1:PG_LSB]) & keep_req);
      pa_c     = {pa_hi, req_va[PG_LSB-1:0]};
      sp_c     = (pg_size_e'(e_size[sel]) == PG_4K) ? e_prot[sel][req_va[11:10]]
                                                     : e_prot[sel][0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_miss    <= 1'b0;
         rsp_multi   <= 1'b0;
         rsp_pa      <= '0;
         rsp_group   <= '0;
         rsp_ci      <= 1'b0;
         rsp_wt      <= 1'b0;
         rsp_subprot <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any_hit;
         rsp_miss  <= req_valid && !any_hit;
         rsp_multi <= req_valid && multi_hit;
         if (req_valid && any_hit) begin
            rsp_pa      <= pa_c;
            rsp_group   <= e_group[sel];
            rsp_ci      <= e_ci[sel];
            rsp_wt      <= e_wt[sel];
            rsp_subprot <= sp_c;
         end else begin
            rsp_pa      <= '0;
            rsp_group   <= '0;
            rsp_ci      <= 1'b0;
            rsp_wt      <= 1'b0;
            rsp_subprot <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int ASID_W  = 4,
   parameter int GRP_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int VPN_W  = VA_W - 12,
   localparam int PFN_W  = PA_W - 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [VA_W-1:0]   req_va,
   input logic [ASID_W-1:0] req_asid,
   input logic              wr_en,
   input logic              wr_use_idx,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [VPN_W-1:0]  wr_vpn,
   input logic [ASID_W-1:0] wr_asid,
   input logic [1:0]        wr_size,
   input logic [PFN_W-1:0]  wr_pfn,
   input logic [GRP_W-1:0]  wr_group,
   input logic              wr_ci,
   input logic              wr_wt,
   input logic [3:0]        wr_prot,
   input logic              inval_all,
   input logic [IDX_W-1:0]  victim_idx,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_miss,
   input logic              rsp_multi,
   input logic [PA_W-1:0]   rsp_pa,
   input logic [GRP_W-1:0]  rsp_group,
   input logic              rsp_ci,
   input logic              rsp_wt,
   input logic              rsp_subprot
);
   logic rr_step;
   assign rr_step = wr_en && !wr_use_idx && !inval_all;

   assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_hit -> rsp_pa[11:0] == $past(req_va[11:0])));

   assert_hit_xor_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));

   assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_pa == '0 && rsp_group == '0 && !rsp_ci && !rsp_wt && !rsp_subprot));

   assert_multi_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_multi |-> rsp_hit);

   assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rr_step |=> victim_idx == (($past(victim_idx) == IDX_W'(ENTRIES - 1)) ? '0
                                 : $past(victim_idx) + 1'b1));

   assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rr_step |=> $stable(victim_idx));

   assert_inval_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all ##1 req_valid |=> rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk #(
   .ENTRIES (ENTRIES),
   .VA_W    (VA_W),
   .PA_W    (PA_W),
   .ASID_W  (ASID_W),
   .GRP_W   (GRP_W)
) u_chk (.*);

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic [3:0]  req_asid = '0;
   logic        wr_en = 1'b0, wr_use_idx = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [19:0] wr_vpn = '0, wr_pfn = '0;
   logic [3:0]  wr_asid = '0, wr_group = '0, wr_prot = '0;
   logic [1:0]  wr_size = '0;
   logic        wr_ci = 1'b0, wr_wt = 1'b0, inval_all = 1'b0;
   logic [4:0]  victim_idx;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_ci, rsp_wt, rsp_subprot;
   logic [31:0] rsp_pa;
   logic [3:0]  rsp_group;

   always #2.5 clk = ~clk;

   tlb_xlate uut (.*);

   int tests = 0, fails = 0;

   // bench model of the contents
   bit          m_v   [N];
   logic [19:0] m_vpn [N];
   logic [19:0] m_pfn [N];
   logic [3:0]  m_asid[N];
   logic [3:0]  m_grp [N];
   logic [3:0]  m_prot[N];
   logic [1:0]  m_sz  [N];
   bit          m_ci  [N];
   bit          m_wt  [N];
   int          exp_victim = 0;

   task automatic check(string req, string what, longint act, longint exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int ign_bits(logic [1:0] sz);
      case (sz)
         2'd0: return 0;
         2'd1: return 2;
         2'd2: return 7;
         default: return 11;
      endcase
   endfunction

   // expected outcome from the requirements
   function automatic void model(input logic [31:0] va, input logic [3:0] asid,
                                 output bit hit, output bit multi, output logic [31:0] pa,
                                 output logic [3:0] grp, output bit ci, output bit wt,
                                 output bit sp);
      int first = -1, cnt = 0;
      for (int i = 0; i < N; i++) begin
         logic [19:0] care;
         care = ~((20'd1 << ign_bits(m_sz[i])) - 20'd1);
         if (m_v[i] && m_asid[i] == asid && ((m_vpn[i] ^ va[31:12]) & care) == 0) begin
            cnt++;
            if (first < 0) first = i;
         end
      end
      hit = (cnt > 0); multi = (cnt > 1);
      pa = '0; grp = '0; ci = 0; wt = 0; sp = 0;
      if (hit) begin
         logic [19:0] care;
         care = ~((20'd1 << ign_bits(m_sz[first])) - 20'd1);
         pa  = {(m_pfn[first] & care) | (va[31:12] & ~care), va[11:0]};
         grp = m_grp[first]; ci = m_ci[first]; wt = m_wt[first];
         sp  = (m_sz[first] == 2'd0) ? m_prot[first][va[11:10]] : m_prot[first][0];
      end
   endfunction

   task automatic drive_write(bit use_idx, int idx, logic [19:0] vpn, logic [3:0] asid,
                              logic [1:0] sz, logic [19:0] pfn, logic [3:0] grp,
                              bit ci, bit wt, logic [3:0] prot);
      int slot;
      wr_en = 1; wr_use_idx = use_idx; wr_idx = 5'(idx); wr_vpn = vpn; wr_asid = asid;
      wr_size = sz; wr_pfn = pfn; wr_group = grp; wr_ci = ci; wr_wt = wt; wr_prot = prot;
      if (!inval_all) begin
         slot = use_idx ? idx : exp_victim;
         m_v[slot] = 1; m_vpn[slot] = vpn; m_asid[slot] = asid; m_sz[slot] = sz;
         m_pfn[slot] = pfn; m_grp[slot] = grp; m_ci[slot] = ci; m_wt[slot] = wt;
         m_prot[slot] = prot;
         if (!use_idx) exp_victim = (exp_victim == N - 1) ? 0 : exp_victim + 1;
      end
   endtask

   task automatic write_entry(bit use_idx, int idx, logic [19:0] vpn, logic [3:0] asid,
                              logic [1:0] sz, logic [19:0] pfn, logic [3:0] grp,
                              bit ci, bit wt, logic [3:0] prot);
      @(negedge clk);
      drive_write(use_idx, idx, vpn, asid, sz, pfn, grp, ci, wt, prot);
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic compare(string req, logic [31:0] va, logic [3:0] asid,
                          bit e_hit, bit e_multi, logic [31:0] e_pa, logic [3:0] e_grp,
                          bit e_ci, bit e_wt, bit e_sp);
      check(req, "rsp_valid", rsp_valid, 1);
      check(req, "rsp_hit", rsp_hit, e_hit);
      check(req, "rsp_miss", rsp_miss, !e_hit);
      check(req, "rsp_multi", rsp_multi, e_multi);
      check(req, "rsp_pa", rsp_pa, e_pa);
      check(req, "rsp_group", rsp_group, e_grp);
      check(req, "rsp_ci", rsp_ci, e_ci);
      check(req, "rsp_wt", rsp_wt, e_wt);
      check(req, "rsp_subprot", rsp_subprot, e_sp);
   endtask

   task automatic lookup(string req, logic [31:0] va, logic [3:0] asid);
      bit h, mu, ci, wt, sp; logic [31:0] pa; logic [3:0] g;
      @(negedge clk);
      req_valid = 1; req_va = va; req_asid = asid;
      model(va, asid, h, mu, pa, g, ci, wt, sp);
      @(posedge clk); #1;
      req_valid = 0;
      compare(req, va, asid, h, mu, pa, g, ci, wt, sp);
   endtask

   function automatic logic [19:0] pfn_of(int i);
      return 20'hABCDE ^ 20'(i * 32'h1357);
   endfunction

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", "rsp_valid in reset", rsp_valid, 0);
      check("R10", "victim_idx in reset", victim_idx, 0);
      rst_n = 1;
      @(posedge clk); #1;
      check("R1", "rsp_valid idle", rsp_valid, 0);

      // R7: empty buffer misses
      lookup("R7", 32'h0000_0123, 4'd0);

      // R9: explicit-slot fill of every slot, sizes cycling, one 8 MB region each
      for (int i = 0; i < N; i++)
         write_entry(1, i, 20'(i << 11), 4'(i % 16), 2'(i % 4), pfn_of(i),
                     4'(15 - i % 16), i[0], i[1], 4'(i) ^ 4'h5);
      check("R9", "victim_idx after indexed writes", victim_idx, 0);

      // R1..R6 sweep over all entries and page sizes
      for (int i = 0; i < N; i++) begin
         int pb;
         logic [31:0] base, omask;
         pb    = 12 + ign_bits(2'(i % 4));
         base  = 32'(i) << 23;
         omask = (32'd1 << pb) - 1;
         lookup("R3", base | (32'h005A_5A5A ^ 32'(i * 32'h3B1)) & omask | base, 4'(i % 16));
         lookup("R5", base | omask, 4'(i % 16));
         for (int q = 0; q < 4; q++)
            lookup("R6", base | (32'(q) << 10) | 32'h0FF, 4'(i % 16));
         lookup("R4", base | 32'h10, 4'((i + 1) % 16));
         if (pb < 23) lookup("R2", base | (32'd1 << pb), 4'(i % 16));
      end

      // R8: overlapping 4 KB entry in slot 30 over the 512 KB page of entry 2
      write_entry(1, 30, 20'(2 << 11), 4'd2, 2'd0, 20'h12345, 4'd9, 1, 1, 4'hF);
      lookup("R8", (32'd2 << 23) | 32'h0000_0ABC, 4'd2);
      lookup("R8", (32'd2 << 23) | 32'h0004_0ABC, 4'd2);
      lookup("R8", (32'd30 << 23) | 32'h0000_0ABC, 4'd14);

      // R12: write and lookup on the same edge
      begin
         bit h, mu, ci, wt, sp; logic [31:0] pa; logic [3:0] g;
         @(negedge clk);
         req_valid = 1; req_va = (32'd5 << 23) | 32'h444; req_asid = 4'd5;
         model(req_va, req_asid, h, mu, pa, g, ci, wt, sp);
         drive_write(1, 5, 20'(5 << 11), 4'd5, 2'd3, 20'h77777, 4'd3, 0, 0, 4'h0);
         @(posedge clk); #1;
         req_valid = 0; wr_en = 0;
         compare("R12", req_va, req_asid, h, mu, pa, g, ci, wt, sp);
         lookup("R12", (32'd5 << 23) | 32'h444, 4'd5);
      end

      // R10: replacement pointer across a full wrap
      for (int k = 0; k < 40; k++) begin
         write_entry(0, 0, 20'hF0000 + 20'(k), 4'd7, 2'd0, 20'h0A000 + 20'(k), 4'd1, 0, 1, 4'h3);
         check("R10", "victim_idx", victim_idx, exp_victim);
      end
      lookup("R10", 32'hF002_7800, 4'd7);
      lookup("R10", 32'hF000_0800, 4'd7);

      // R11: invalidate-all, then a write dropped by a simultaneous invalidate
      @(negedge clk); inval_all = 1;
      for (int i = 0; i < N; i++) m_v[i] = 0;
      @(posedge clk); #1; inval_all = 0;
      lookup("R11", 32'hF002_7800, 4'd7);
      lookup("R11", (32'd5 << 23) | 32'h444, 4'd5);
      begin
         int v0;
         v0 = exp_victim;
         @(negedge clk); inval_all = 1;
         drive_write(0, 0, 20'h00100, 4'd1, 2'd0, 20'h00200, 4'd2, 0, 0, 4'h1);
         @(posedge clk); #1; inval_all = 0; wr_en = 0;
         check("R11", "victim_idx after dropped write", victim_idx, v0);
      end
      lookup("R11", 32'h0010_0000, 4'd1);
      write_entry(0, 0, 20'h00100, 4'd1, 2'd1, 20'h00200, 4'd2, 1, 0, 4'h1);
      lookup("R2", 32'h0010_3FFC, 4'd1);

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule